// File: doc/BRIEF.md
# Multicast Buffer Loan Scoreboard

This block tracks packet buffers from a reserved multicast pool while they are lent to several transmit ports at once. The buffer is not copied. When a loan arrives with a buffer index and a bitmap of destination ports, the block stores that bitmap as the buffer's set of current borrowers. Each port later hands the buffer back by sending its port number and the buffer index. The block then clears that port's bit. When no borrower is left, the block appends the buffer index to a multicast free queue. The allocator pops buffers from that queue for reuse.

The buffer index sent with a return selects the scoreboard entry directly, so no search is needed. A return from a port that does not hold the buffer changes nothing and raises an error flag. A loan with an empty port mask puts the buffer straight back on the queue. A loan and a return can arrive in the same cycle:
- If they name different buffers, both take effect.
- If they name the same buffer, the loan is applied first.
- If both free a buffer in that cycle, the buffer freed by the return is queued ahead of the one freed by the loan.

Top module: `mcast_loan_board`

## Requirements
- R1: A loan (`loan_valid`=1) sets the borrower bitmap of entry `loan_buf` to `loan_mask`. Bit p of the mask means port p borrowed the buffer. A return (`ret_valid`=1) from port `ret_port` whose bit is set clears only that bit. A buffer with any bit still set is not queued.
- R2: When a return clears the last set bit of a buffer, that buffer index is appended to the free queue. It is visible on `fq_buf` (when it reaches the head) after the clock edge that samples the return.
- R3: A return whose port bit is clear for that buffer leaves the scoreboard unchanged. It drives `err_bad_return` high for exactly the one cycle that follows the sampling edge.
- R4: A loan with `loan_mask`=0 appends `loan_buf` to the free queue at the same edge. No bitmap is left behind.
- R5: A loan and a return in the same cycle that name different buffers are both applied.
- R6: A loan and a return in the same cycle that name the same buffer apply the loan first. The return then acts on the newly loaned bitmap. With an empty loan mask, this means an immediate free and a bad-return error.
- R7: When a return and an empty-mask loan both free a buffer in one cycle, the return's buffer enters the free queue first.
- R8: The free queue is first-in first-out and holds up to `NUM_BUFS` indices. `fq_valid` shows it is not empty. `fq_buf` is the head, and it holds still until `fq_pop` is high in a cycle with `fq_valid`=1.
- R9: Reset clears every bitmap and empties the free queue, with `fq_valid`=0 and `err_bad_return`=0. The asynchronous reset is released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loan_valid | input | 1 | Loan request strobe |
| loan_buf | input | $clog2(NUM_BUFS) | Buffer being lent |
| loan_mask | input | NUM_PORTS | Borrowing ports, bit p = port p |
| ret_valid | input | 1 | Return strobe |
| ret_buf | input | $clog2(NUM_BUFS) | Buffer being returned |
| ret_port | input | $clog2(NUM_PORTS) | Port that returns it |
| fq_pop | input | 1 | Take the head of the free queue |
| fq_valid | output | 1 | Free queue not empty |
| fq_buf | output | $clog2(NUM_BUFS) | Head buffer index of the free queue |
| err_bad_return | output | 1 | Return from a port that held no loan |

## Verification
The main function is tried with several input patterns:
- A two-port loan drained one return at a time. This separates a partial return from the final one.
- A return from a port that never borrowed, placed between the good returns. This shows the error leaves the bitmap intact.
- Loans and returns in the same cycle, on different buffers and on one shared buffer. These tell apart the two ordering cases.
- Simultaneous frees from a return and from an empty-mask loan. This exposes the queueing order.
- Filling the queue with every buffer and draining it. This tests FIFO order at full depth.
- A reset taken while a loan is outstanding, followed by a return. This must be reported as bad.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

  typedef enum logic [1:0] {
    PUSH_NONE = 2'd0,
    PUSH_ONE  = 2'd1,
    PUSH_TWO  = 2'd2
  } push_cnt_e;

  function automatic push_cnt_e push_count(input logic a, input logic b);
    if (a && b) return PUSH_TWO;
    if (a || b) return PUSH_ONE;
    return PUSH_NONE;
  endfunction

endpackage

// File: rtl/mcl_score_table.sv
module mcl_score_table #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_BUFS  = 16,
  localparam int IDXW = $clog2(NUM_BUFS),
  localparam int PW   = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 loan_valid,
  input  logic [IDXW-1:0]      loan_buf,
  input  logic [NUM_PORTS-1:0] loan_mask,
  input  logic                 ret_valid,
  input  logic [IDXW-1:0]      ret_buf,
  input  logic [PW-1:0]        ret_port,
  output logic                 ret_frees,
  output logic                 loan_frees,
  output logic                 ret_bad
);

  logic [NUM_PORTS-1:0] owners_q [NUM_BUFS];
  logic [NUM_PORTS-1:0] owners_d [NUM_BUFS];
  logic [NUM_BUFS-1:0]  hit_ok;
  logic [NUM_BUFS-1:0]  hit_free;
  logic [NUM_PORTS-1:0] port_bit;
  logic                 port_in_range;

  always_comb begin
    port_bit      = '0;
    port_bit[ret_port] = 1'b1;
    port_in_range = int'(ret_port) < NUM_PORTS;
  end

  for (genvar i = 0; i < NUM_BUFS; i++) begin : g_entry
    logic [NUM_PORTS-1:0] after_loan;
    logic                 loan_hit;
    logic                 ret_hit;

    always_comb begin
      loan_hit   = loan_valid && (loan_buf == IDXW'(i));
      ret_hit    = ret_valid && (ret_buf == IDXW'(i));
      after_loan = loan_hit ? loan_mask : owners_q[i];
      hit_ok[i]  = ret_hit && port_in_range && ((after_loan & port_bit) != '0);
      owners_d[i] = hit_ok[i] ? (after_loan & ~port_bit) : after_loan;
      hit_free[i] = hit_ok[i] && (owners_d[i] == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        owners_q[i] <= '0;
      end else if (loan_hit || hit_ok[i]) begin
        owners_q[i] <= owners_d[i];
      end
    end
  end

  always_comb begin
    ret_frees  = |hit_free;
    loan_frees = loan_valid && (loan_mask == '0);
    ret_bad    = ret_valid && !(|hit_ok);
  end

endmodule

// File: rtl/mcl_free_fifo.sv
module mcl_free_fifo
  import mcl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_push,
  input  logic [DW-1:0] a_data,
  input  logic          b_push,
  input  logic [DW-1:0] b_data,
  input  logic          pop,
  output logic          not_empty,
  output logic [DW-1:0] head,
  output logic [CW-1:0] fill
);

  logic [DW-1:0] slots [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d, b_slot;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop;
  push_cnt_e     npush;

  always_comb begin
    npush  = push_count(a_push, b_push);
    do_pop = pop && (cnt_q != '0);
    b_slot = a_push ? AW'(wr_q + 1'b1) : wr_q;
    wr_d   = AW'(wr_q + AW'(npush));
    rd_d   = do_pop ? AW'(rd_q + 1'b1) : rd_q;
    cnt_d  = CW'(cnt_q + CW'(npush) - CW'(do_pop));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (npush != PUSH_NONE) wr_q <= wr_d;
      if (do_pop) rd_q <= rd_d;
      if ((npush != PUSH_NONE) || do_pop) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (a_push) slots[wr_q] <= a_data;
    if (b_push) slots[b_slot] <= b_data;
  end

  always_comb begin
    not_empty = cnt_q != '0;
    head      = slots[rd_q];
    fill      = cnt_q;
  end

endmodule

// File: rtl/mcast_loan_board.sv
module mcast_loan_board #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_BUFS  = 16,
  localparam int IDXW = $clog2(NUM_BUFS),
  localparam int PW   = $clog2(NUM_PORTS),
  localparam int CW   = $clog2(NUM_BUFS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 loan_valid,
  input  logic [IDXW-1:0]      loan_buf,
  input  logic [NUM_PORTS-1:0] loan_mask,
  input  logic                 ret_valid,
  input  logic [IDXW-1:0]      ret_buf,
  input  logic [PW-1:0]        ret_port,
  input  logic                 fq_pop,
  output logic                 fq_valid,
  output logic [IDXW-1:0]      fq_buf,
  output logic                 err_bad_return
);

  logic [1:0]    rst_pipe_q;
  logic          rst_q_n;
  logic          ret_frees, loan_frees, ret_bad;
  logic          err_q, err_d;
  logic [CW-1:0] fq_fill;

  // asynchronous assertion, release aligned to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  mcl_score_table #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_BUFS (NUM_BUFS)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .loan_valid(loan_valid),
    .loan_buf  (loan_buf),
    .loan_mask (loan_mask),
    .ret_valid (ret_valid),
    .ret_buf   (ret_buf),
    .ret_port  (ret_port),
    .ret_frees (ret_frees),
    .loan_frees(loan_frees),
    .ret_bad   (ret_bad)
  );

  // return-freed buffer takes the earlier queue slot
  mcl_free_fifo #(
    .DEPTH(NUM_BUFS),
    .DW   (IDXW)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .a_push   (ret_frees),
    .a_data   (ret_buf),
    .b_push   (loan_frees),
    .b_data   (loan_buf),
    .pop      (fq_pop),
    .not_empty(fq_valid),
    .head     (fq_buf),
    .fill     (fq_fill)
  );

  always_comb err_d = ret_bad;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  assign err_bad_return = err_q;

endmodule

// File: rtl/mcast_loan_board_chk.sv
module mcast_loan_board_chk #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_BUFS  = 16,
  localparam int IDXW = $clog2(NUM_BUFS),
  localparam int PW   = $clog2(NUM_PORTS),
  localparam int CW   = $clog2(NUM_BUFS + 1)
) (
  input logic                 clk,
  input logic                 rst_q_n,
  input logic                 loan_valid,
  input logic [IDXW-1:0]      loan_buf,
  input logic [NUM_PORTS-1:0] loan_mask,
  input logic                 ret_valid,
  input logic [IDXW-1:0]      ret_buf,
  input logic                 fq_pop,
  input logic                 fq_valid,
  input logic [IDXW-1:0]      fq_buf,
  input logic                 err_bad_return,
  input logic [CW-1:0]        fq_fill
);

  a_r4_empty_loan_queues: assert property (@(posedge clk) disable iff (!rst_q_n)
    (loan_valid && loan_mask == '0) |=> fq_valid);

  a_r6_same_buf_empty_err: assert property (@(posedge clk) disable iff (!rst_q_n)
    (loan_valid && ret_valid && loan_buf == ret_buf && loan_mask == '0) |=> err_bad_return);

  a_r3_err_needs_return: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_bad_return |-> $past(ret_valid));

  a_r8_head_holds: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fq_valid && !fq_pop) |=> (fq_valid && $stable(fq_buf)));

  a_r8_idle_stays_empty: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!fq_valid && !loan_valid && !ret_valid) |=> !fq_valid);

  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_q_n)
    int'(fq_fill) <= NUM_BUFS);

endmodule

bind mcast_loan_board mcast_loan_board_chk #(
  .NUM_PORTS(NUM_PORTS),
  .NUM_BUFS (NUM_BUFS)
) u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .loan_valid    (loan_valid),
  .loan_buf      (loan_buf),
  .loan_mask     (loan_mask),
  .ret_valid     (ret_valid),
  .ret_buf       (ret_buf),
  .fq_pop        (fq_pop),
  .fq_valid      (fq_valid),
  .fq_buf        (fq_buf),
  .err_bad_return(err_bad_return),
  .fq_fill       (fq_fill)
);

// File: tb/mcast_loan_board_test.sv
module mcast_loan_board_test;

  localparam int NP = 8;
  localparam int NB = 16;

  logic       clk;
  logic       rst_n;
  logic       loan_valid;
  logic [3:0] loan_buf;
  logic [7:0] loan_mask;
  logic       ret_valid;
  logic [3:0] ret_buf;
  logic [2:0] ret_port;
  logic       fq_pop;
  logic       fq_valid;
  logic [3:0] fq_buf;
  logic       err_bad_return;

  int applied = 0;
  int bad = 0;
  bit done = 0;

  mcast_loan_board #(.NUM_PORTS(NP), .NUM_BUFS(NB)) uut (
    .clk(clk), .rst_n(rst_n),
    .loan_valid(loan_valid), .loan_buf(loan_buf), .loan_mask(loan_mask),
    .ret_valid(ret_valid), .ret_buf(ret_buf), .ret_port(ret_port),
    .fq_pop(fq_pop), .fq_valid(fq_valid), .fq_buf(fq_buf),
    .err_bad_return(err_bad_return)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic       pop;
    logic       lv;
    logic [3:0] lb;
    logic [7:0] lm;
    logic       rv;
    logic [3:0] rb;
    logic [2:0] rp;
    logic       e_err;
    logic       e_fv;
    logic [3:0] e_fb;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 4'd3, 8'h05, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 4'd0}, // R1 loan ports 0,2
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 4'd3, 3'd0, 1'b0, 1'b0, 4'd0}, // R1 partial return
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 4'd3, 3'd1, 1'b1, 1'b0, 4'd0}, // R3 port 1 never held it
    '{1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 4'd3, 3'd2, 1'b0, 1'b1, 4'd3}, // R2 last return frees
    '{1'b1, 1'b1, 4'd5, 8'h00, 1'b0, 4'd0, 3'd0, 1'b0, 1'b1, 4'd5}, // R4 empty mask
    '{1'b1, 1'b1, 4'd7, 8'h80, 1'b1, 4'd9, 3'd0, 1'b1, 1'b0, 4'd0}, // R3 return of unlent buf
    '{1'b0, 1'b1, 4'd9, 8'h03, 1'b1, 4'd7, 3'd7, 1'b0, 1'b1, 4'd7}, // R5 different buffers
    '{1'b1, 1'b1, 4'd2, 8'h10, 1'b1, 4'd2, 3'd4, 1'b0, 1'b1, 4'd2}, // R6 loan then return
    '{1'b1, 1'b1, 4'd4, 8'h00, 1'b1, 4'd9, 3'd0, 1'b0, 1'b1, 4'd4}, // R5 buf9 partial
    '{1'b0, 1'b1, 4'd6, 8'h00, 1'b1, 4'd9, 3'd1, 1'b0, 1'b1, 4'd4}, // R7 two frees
    '{1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 3'd0, 1'b0, 1'b1, 4'd9}, // R7 return first
    '{1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 3'd0, 1'b0, 1'b1, 4'd6}, // R7 loan second
    '{1'b1, 1'b1, 4'd1, 8'h00, 1'b1, 4'd1, 3'd0, 1'b1, 1'b1, 4'd1}, // R6 same buf empty mask
    '{1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 4'd0}  // R8 drained
  };

  task automatic check(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    loan_valid = 1'b0; loan_buf = '0; loan_mask = '0;
    ret_valid = 1'b0; ret_buf = '0; ret_port = '0; fq_pop = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 fq_valid after reset", int'(fq_valid), 0);
    check("R9 err after reset", int'(err_bad_return), 0);

    for (int i = 0; i < NV; i++) begin
      fq_pop = VECS[i].pop;
      loan_valid = VECS[i].lv; loan_buf = VECS[i].lb; loan_mask = VECS[i].lm;
      ret_valid = VECS[i].rv; ret_buf = VECS[i].rb; ret_port = VECS[i].rp;
      @(posedge clk);
      #1;
      check($sformatf("R1-table vec %0d err", i), int'(err_bad_return), int'(VECS[i].e_err));
      check($sformatf("R2 vec %0d fq_valid", i), int'(fq_valid), int'(VECS[i].e_fv));
      if (VECS[i].e_fv)
        check($sformatf("R8 vec %0d fq_buf", i), int'(fq_buf), int'(VECS[i].e_fb));
      @(negedge clk);
      idle();
    end

    // R3: error lasts one cycle only
    ret_valid = 1'b1; ret_buf = 4'd11; ret_port = 3'd5;
    step();
    check("R3 err set", int'(err_bad_return), 1);
    step();
    check("R3 err one cycle", int'(err_bad_return), 0);

    // R8: fill with every buffer, drain in order
    for (int b = 0; b < NB; b++) begin
      loan_valid = 1'b1; loan_buf = 4'(b); loan_mask = '0;
      step();
    end
    for (int b = 0; b < NB; b++) begin
      check("R8 full-depth valid", int'(fq_valid), 1);
      check("R8 full-depth order", int'(fq_buf), b);
      fq_pop = 1'b1;
      step();
    end
    check("R8 empty after drain", int'(fq_valid), 0);

    // R9: reset clears an outstanding loan
    loan_valid = 1'b1; loan_buf = 4'd0; loan_mask = 8'h01;
    step();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ret_valid = 1'b1; ret_buf = 4'd0; ret_port = 3'd0;
    step();
    check("R9 loan cleared by reset", int'(err_bad_return), 1);
    check("R9 queue empty after reset", int'(fq_valid), 0);

    finish_run();
  end

endmodule